// File: doc/BRIEF.md
# Prefixed Instruction Addressing Decoder

This block classifies the addressing of an 8-bit CISC instruction stream that arrives one byte per accepted cycle. An instruction may start with a single prefix byte that changes how the following opcode is read. A prefix can exchange the two index registers, or it can turn an indexed or absolute mode into a memory-indirect one with an 8-bit or 16-bit pointer address. The decoder holds the prefix in a register. When the opcode arrives, it reports the addressing mode, the index register, whether a word register operand is taken from Y, whether a pointer fetch is needed and how wide the pointer address is, and how many operand bytes follow.

The decode is combinational from the registered prefix and the incoming byte. It is valid in the same cycle in which the opcode byte is accepted. The decoder then counts the following operand bytes and flags each one, so that it never decodes an operand as an opcode. The decoder handles only the one-operand and two-operand opcode groups. Branches, miscellaneous, bit-manipulation and far-access opcodes, reassigned codes, and prefix/opcode pairs that have no addressing meaning are all reported as "other". A second prefix that arrives right after a prefix is flagged as an illegal sequence and dropped.

Top module: `pfx_addr_decoder`

## Requirements
- R1: A byte of value 0x72, 0x90, 0x91 or 0x92 accepted while idle is held as a prefix. That cycle shows no decode and no illegal flag, and the next accepted byte is decoded under that prefix.
- R2: A prefix byte accepted while a prefix is already held pulses `illegal_o` for that cycle with no decode. Both prefixes are dropped, and the next byte is decoded as an unprefixed opcode.
- R3: Unprefixed one-operand group (high nibble 0,3,4,5,6,7; low nibble not 1,2,5,B) maps the high nibble to modes 0→stack+addr8 (code 1, 1 byte), 3→addr8 (2, 1), 4→accumulator (5, 0), 5→16-bit register (6, 0), 6→addr8+index (8, 1), 7→index no offset (7, 0).
- R4: Under prefix 0x72, one-operand nibbles map 3→[addr16] (code 11, 2 bytes), 4→addr16+X (9, 2), 5→addr16 (3, 2), 6→[addr16]+X (13, 2). Other nibbles are "other".
- R5: Unprefixed two-operand group (high nibble 1,A–F) maps 1→stack+addr8 (1, 1 byte), A→imm8 (4, 1), B→addr8 (2, 1), C→addr16 (3, 2), D→addr16+index (9, 2), E→addr8+index (8, 1), F→index no offset (7, 0).
- R6: Prefix 0x92 gives [addr8] (code 10) for one-operand nibble 3 and two-operand nibble C, and [addr8]+X (code 12) for one-operand nibble 6 and two-operand nibble D. Prefix 0x91 gives [addr8]+Y (code 12) for nibbles 6 (one-operand) and D (two-operand). Prefix 0x72 gives [addr16] (11) and [addr16]+X (13) for two-operand nibbles C and D. All these 8-bit indirect forms carry 1 operand byte, and the 16-bit ones carry 2.
- R7: `idx_y_o` is 1 only for index-using modes (codes 7,8,9,12,13) and the 16-bit register mode (6), and only under prefix 0x90 or 0x91.
- R8: For a two-operand word compare (low nibble 3) or word load (low nibble E), `reg_swap_o` (register operand is Y) equals the inverse of `idx_y_o` in index-using modes, and equals "prefix is 0x90" in other modes. It is 0 for every other opcode.
- R9: After a decode with count N>0, the next N accepted bytes raise `opnd_valid_o`, produce no decode and are never taken as prefixes. Cycles without `byte_valid_i` do not consume the count.
- R10: Opcodes outside both groups, the reassigned codes (one-operand low nibble 1,2,5,B; 0x1C, 0x1D, 0xA7, 0xAC, 0xAD, 0xAF, 0xBC, 0xBD), and prefix/nibble pairs not listed in R4 or R6 all decode with `other_o`=1, mode 0 and count 0.
- R11: Asynchronous reset returns the decoder to idle: a held prefix is discarded, and every output is 0 while no byte is offered.
- R12: `indirect_o` is 1 exactly for modes 10–13, and `ptr_wide_o` is 1 exactly for modes 11 and 13. Decode fields are 0 in cycles without a decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | Instruction byte offered and accepted this cycle |
| byte_i | input | 8 | Instruction byte |
| dec_valid_o | output | 1 | This byte was decoded as an opcode |
| mode_o | output | 4 | Addressing mode code (0 = none) |
| idx_y_o | output | 1 | Index register is Y |
| reg_swap_o | output | 1 | Word register operand is Y |
| indirect_o | output | 1 | Pointer fetch from memory needed |
| ptr_wide_o | output | 1 | Pointer address is 16 bits (else 8) |
| opnd_bytes_o | output | 2 | Operand bytes following the opcode |
| other_o | output | 1 | Opcode outside the handled groups |
| opnd_valid_o | output | 1 | This byte is an operand byte |
| illegal_o | output | 1 | Prefix followed a prefix |

## Verification
On every cycle, the assertions check several properties. At most one of decode, operand and illegal events occurs per byte, and none occurs without a valid byte. Counts stay in range, a wide pointer always implies indirection, and "other" carries no operand bytes. A decode with operand bytes is never followed straight away by another decode. The word-register swap relation is also checked against the opcode on the port. Only the bench scenarios can show the exact mode chosen for each prefix and opcode pair, how the illegal double prefix recovers, that a prefix held across reset is dropped, and that operand counting works across idle gaps.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_OPND = 2;
  localparam int CNT_W    = $clog2(MAX_OPND + 1);
  localparam int MODE_W   = 4;

  typedef enum logic [2:0] {PF_NONE, PF_72, PF_90, PF_91, PF_92} pfx_e;

  typedef enum logic [MODE_W-1:0] {
    MD_NONE      = 4'd0,
    MD_SP8       = 4'd1,
    MD_ABS8      = 4'd2,
    MD_ABS16     = 4'd3,
    MD_IMM8      = 4'd4,
    MD_ACC       = 4'd5,
    MD_REG16     = 4'd6,
    MD_IDX0      = 4'd7,
    MD_IDX8      = 4'd8,
    MD_IDX16     = 4'd9,
    MD_IND8      = 4'd10,
    MD_IND16     = 4'd11,
    MD_IND8_IDX  = 4'd12,
    MD_IND16_IDX = 4'd13
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic             idx_y;
    logic             reg_swap;
    logic             indirect;
    logic             ptr_wide;
    logic [CNT_W-1:0] cnt;
  } dec_s;

  function automatic logic uses_index(mode_e m);
    return m inside {MD_IDX0, MD_IDX8, MD_IDX16, MD_IND8_IDX, MD_IND16_IDX};
  endfunction

  function automatic logic [CNT_W-1:0] opnd_count(mode_e m);
    case (m)
      MD_ABS16, MD_IDX16, MD_IND16, MD_IND16_IDX: return CNT_W'(2);
      MD_SP8, MD_ABS8, MD_IMM8, MD_IDX8, MD_IND8, MD_IND8_IDX: return CNT_W'(1);
      default: return CNT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/pad_pfx_detect.sv
module pad_pfx_detect
  import pad_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_pfx_o,
  output pfx_e              kind_o
);
  always_comb begin
    is_pfx_o = 1'b1;
    case (byte_i)
      8'h72:   kind_o = PF_72;
      8'h90:   kind_o = PF_90;
      8'h91:   kind_o = PF_91;
      8'h92:   kind_o = PF_92;
      default: begin
        kind_o   = PF_NONE;
        is_pfx_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pad_classify.sv
module pad_classify
  import pad_pkg::*;
(
  input  pfx_e              pfx_i,
  input  logic [BYTE_W-1:0] op_i,
  output dec_s              dec_o
);
  logic [3:0] hi, lo;
  logic       one_grp, two_grp, word_op, swap_pfx;
  mode_e      mode;

  assign hi = op_i[7:4];
  assign lo = op_i[3:0];
  assign one_grp = (hi inside {4'h0, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7}) &&
                   !(lo inside {4'h1, 4'h2, 4'h5, 4'hB});
  assign two_grp = (hi inside {4'h1, [4'hA:4'hF]}) &&
                   !(op_i inside {8'h1C, 8'h1D, 8'hA7, 8'hAC, 8'hAD, 8'hAF, 8'hBC, 8'hBD});
  assign swap_pfx = (pfx_i == PF_90) || (pfx_i == PF_91);

  always_comb begin
    mode = MD_NONE;
    if (one_grp) begin
      case (pfx_i)
        PF_NONE, PF_90:
          case (hi)
            4'h0:    mode = MD_SP8;
            4'h3:    mode = MD_ABS8;
            4'h4:    mode = MD_ACC;
            4'h5:    mode = MD_REG16;
            4'h6:    mode = MD_IDX8;
            4'h7:    mode = MD_IDX0;
            default: mode = MD_NONE;
          endcase
        PF_72:
          case (hi)
            4'h3:    mode = MD_IND16;
            4'h4:    mode = MD_IDX16;
            4'h5:    mode = MD_ABS16;
            4'h6:    mode = MD_IND16_IDX;
            default: mode = MD_NONE;
          endcase
        PF_92:
          case (hi)
            4'h3:    mode = MD_IND8;
            4'h6:    mode = MD_IND8_IDX;
            default: mode = MD_NONE;
          endcase
        PF_91:   mode = (hi == 4'h6) ? MD_IND8_IDX : MD_NONE;
        default: mode = MD_NONE;
      endcase
    end else if (two_grp) begin
      case (pfx_i)
        PF_NONE, PF_90:
          case (hi)
            4'h1:    mode = MD_SP8;
            4'hA:    mode = MD_IMM8;
            4'hB:    mode = MD_ABS8;
            4'hC:    mode = MD_ABS16;
            4'hD:    mode = MD_IDX16;
            4'hE:    mode = MD_IDX8;
            4'hF:    mode = MD_IDX0;
            default: mode = MD_NONE;
          endcase
        PF_72:
          case (hi)
            4'hC:    mode = MD_IND16;
            4'hD:    mode = MD_IND16_IDX;
            default: mode = MD_NONE;
          endcase
        PF_92:
          case (hi)
            4'hC:    mode = MD_IND8;
            4'hD:    mode = MD_IND8_IDX;
            default: mode = MD_NONE;
          endcase
        PF_91:   mode = (hi == 4'hD) ? MD_IND8_IDX : MD_NONE;
        default: mode = MD_NONE;
      endcase
    end
  end

  // word compare / word load carry a register operand that may be Y
  assign word_op = two_grp && (lo == 4'h3 || lo == 4'hE) && (mode != MD_NONE);

  always_comb begin
    dec_o.mode     = mode;
    dec_o.idx_y    = (uses_index(mode) || mode == MD_REG16) && swap_pfx;
    dec_o.indirect = mode inside {MD_IND8, MD_IND16, MD_IND8_IDX, MD_IND16_IDX};
    dec_o.ptr_wide = mode inside {MD_IND16, MD_IND16_IDX};
    dec_o.cnt      = opnd_count(mode);
    if (!word_op)              dec_o.reg_swap = 1'b0;
    else if (uses_index(mode)) dec_o.reg_swap = !dec_o.idx_y;
    else                       dec_o.reg_swap = (pfx_i == PF_90);
  end
endmodule

// File: rtl/pad_seq.sv
module pad_seq
  import pad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             is_pfx_i,
  input  pfx_e             kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  output pfx_e             cur_pfx_o,
  output logic             dec_fire_o,
  output logic             opnd_fire_o,
  output logic             illegal_o
);
  typedef enum logic [1:0] {S_IDLE, S_PFX, S_OPND} st_e;

  st_e              st_q;
  pfx_e             pfx_q;
  logic [CNT_W-1:0] cnt_q;

  assign cur_pfx_o   = (st_q == S_PFX) ? pfx_q : PF_NONE;
  assign dec_fire_o  = valid_i && !is_pfx_i && (st_q != S_OPND);
  assign opnd_fire_o = valid_i && (st_q == S_OPND);
  assign illegal_o   = valid_i && is_pfx_i && (st_q == S_PFX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      pfx_q <= PF_NONE;
      cnt_q <= '0;
    end else if (valid_i) begin
      case (st_q)
        S_IDLE, S_PFX: begin
          if (illegal_o) begin
            st_q  <= S_IDLE;
            pfx_q <= PF_NONE;
          end else if (is_pfx_i) begin
            st_q  <= S_PFX;
            pfx_q <= kind_i;
          end else if (cnt_i != '0) begin
            st_q  <= S_OPND;
            cnt_q <= cnt_i;
            pfx_q <= PF_NONE;
          end else begin
            st_q  <= S_IDLE;
            pfx_q <= PF_NONE;
          end
        end
        S_OPND: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfx_addr_decoder.sv
module pfx_addr_decoder
  import pad_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              dec_valid_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              idx_y_o,
  output logic              reg_swap_o,
  output logic              indirect_o,
  output logic              ptr_wide_o,
  output logic [CNT_W-1:0]  opnd_bytes_o,
  output logic              other_o,
  output logic              opnd_valid_o,
  output logic              illegal_o
);
  logic is_pfx, dec_fire;
  pfx_e kind, cur_pfx;
  dec_s dec;

  pad_pfx_detect u_det (
    .byte_i  (byte_i),
    .is_pfx_o(is_pfx),
    .kind_o  (kind)
  );

  pad_classify u_cls (
    .pfx_i(cur_pfx),
    .op_i (byte_i),
    .dec_o(dec)
  );

  pad_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (byte_valid_i),
    .is_pfx_i   (is_pfx),
    .kind_i     (kind),
    .cnt_i      (dec.cnt),
    .cur_pfx_o  (cur_pfx),
    .dec_fire_o (dec_fire),
    .opnd_fire_o(opnd_valid_o),
    .illegal_o  (illegal_o)
  );

  assign dec_valid_o  = dec_fire;
  assign mode_o       = dec_fire ? dec.mode : MD_NONE;
  assign idx_y_o      = dec_fire && dec.idx_y;
  assign reg_swap_o   = dec_fire && dec.reg_swap;
  assign indirect_o   = dec_fire && dec.indirect;
  assign ptr_wide_o   = dec_fire && dec.ptr_wide;
  assign opnd_bytes_o = dec_fire ? dec.cnt : '0;
  assign other_o      = dec_fire && (dec.mode == MD_NONE);
endmodule

// File: rtl/pfx_addr_decoder_chk.sv
module pfx_addr_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_i,
  input logic [7:0] byte_i,
  input logic       dec_valid_o,
  input logic [3:0] mode_o,
  input logic       idx_y_o,
  input logic       reg_swap_o,
  input logic       indirect_o,
  input logic       ptr_wide_o,
  input logic [1:0] opnd_bytes_o,
  input logic       other_o,
  input logic       opnd_valid_o,
  input logic       illegal_o
);
  logic idx_mode, word_op;
  assign idx_mode = mode_o inside {4'd7, 4'd8, 4'd9, 4'd12, 4'd13};
  assign word_op  = (byte_i[7:4] inside {4'h1, [4'hA:4'hF]}) &&
                    (byte_i[3:0] == 4'h3 || byte_i[3:0] == 4'hE);

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_valid_o, opnd_valid_o, illegal_o}));  // R9
  AST_NO_EVENT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |-> !(dec_valid_o || opnd_valid_o || illegal_o));  // R12
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> opnd_bytes_o <= 2'd2);  // R9
  AST_OPND_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && opnd_bytes_o != 2'd0) |=> !dec_valid_o && !illegal_o);  // R9
  AST_ILLEGAL_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !opnd_valid_o && !illegal_o);  // R2
  AST_WIDE_INDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wide_o |-> indirect_o && dec_valid_o);  // R12
  AST_OTHER_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_o |-> mode_o == 4'd0 && opnd_bytes_o == 2'd0 && !indirect_o && !idx_y_o);  // R10
  AST_WORD_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && word_op && idx_mode) |-> reg_swap_o != idx_y_o);  // R8
endmodule

bind pfx_addr_decoder pfx_addr_decoder_chk chk_i (.*);

// File: tb/pfx_addr_decoder_tb.sv
module pfx_addr_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int SEED  = 7331;
  localparam int NRAND = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bv = 1'b0;
  logic [7:0] bi = 8'h00;
  logic       dec_v, idx_y, rswap, ind, wide, oth, opv, ill;
  logic [3:0] mode;
  logic [1:0] cnt;
  int         checks = 0;
  int         fails = 0;

  always #(CLK_P/2) clk = ~clk;

  pfx_addr_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bi),
    .dec_valid_o(dec_v), .mode_o(mode), .idx_y_o(idx_y), .reg_swap_o(rswap),
    .indirect_o(ind), .ptr_wide_o(wide), .opnd_bytes_o(cnt), .other_o(oth),
    .opnd_valid_o(opv), .illegal_o(ill)
  );

  // prefix code: 0 none, 1 0x72, 2 0x90, 3 0x91, 4 0x92
  function automatic int ref_mode(int p, logic [7:0] op);
    logic [3:0] h, l;
    h = op[7:4]; l = op[3:0];
    if ((h inside {0, 3, 4, 5, 6, 7}) && !(l inside {1, 2, 5, 11})) begin
      if (p == 0 || p == 2)
        case (h) 0: return 1; 3: return 2; 4: return 5; 5: return 6; 6: return 8; default: return 7; endcase
      if (p == 1)
        case (h) 3: return 11; 4: return 9; 5: return 3; 6: return 13; default: return 0; endcase
      if (p == 4)
        case (h) 3: return 10; 6: return 12; default: return 0; endcase
      return (h == 6) ? 12 : 0;
    end
    if ((h == 1 || h >= 4'hA) &&
        !(op inside {8'h1C, 8'h1D, 8'hA7, 8'hAC, 8'hAD, 8'hAF, 8'hBC, 8'hBD})) begin
      if (p == 0 || p == 2)
        case (h) 1: return 1; 10: return 4; 11: return 2; 12: return 3; 13: return 9; 14: return 8; default: return 7; endcase
      if (p == 1) case (h) 12: return 11; 13: return 13; default: return 0; endcase
      if (p == 4) case (h) 12: return 10; 13: return 12; default: return 0; endcase
      return (h == 13) ? 12 : 0;
    end
    return 0;
  endfunction

  function automatic logic [11:0] ref_vec(int p, logic [7:0] op);
    int m, c;
    logic ix, y, w, sw;
    m  = ref_mode(p, op);
    c  = (m inside {3, 9, 11, 13}) ? 2 : (m inside {1, 2, 4, 8, 10, 12}) ? 1 : 0;
    ix = m inside {7, 8, 9, 12, 13};
    y  = (ix || m == 6) && (p == 2 || p == 3);
    w  = (op[7:4] == 1 || op[7:4] >= 4'hA) && (op[3:0] == 3 || op[3:0] == 14) && m != 0;
    sw = !w ? 1'b0 : ix ? !y : (p == 2);
    return {1'b1, 4'(m), y, sw, 1'(m >= 10), 1'(m == 11 || m == 13), 2'(c), 1'(m == 0)};
  endfunction

  function automatic logic [11:0] act_vec();
    return {dec_v, mode, idx_y, rswap, ind, wide, cnt, oth};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk); bv = 1'b1; bi = b; #1;
  endtask

  task automatic gap();
    @(negedge clk); bv = 1'b0; #1;
  endtask

  function automatic logic [7:0] pbyte(int p);
    case (p) 1: return 8'h72; 2: return 8'h90; 3: return 8'h91; default: return 8'h92; endcase
  endfunction

  // full instruction with operand bytes and optional bubbles
  task automatic instr(string req, int p, logic [7:0] op, bit bubbles);
    logic [11:0] e;
    if (p != 0) begin
      put(pbyte(p));
      check("R1 prefix silent", {dec_v, ill, opv}, 3'b000);
      if (bubbles && $urandom % 3 == 0) gap();
    end
    put(op);
    e = ref_vec(p, op);
    check(req, act_vec(), e);
    for (int k = 0; k < int'(e[2:1]); k++) begin
      if (bubbles && $urandom % 4 == 0) gap();
      put(8'(($urandom % 2) ? pbyte(1 + $urandom % 4) : 8'($urandom)));
      check("R9 operand byte", {opv, dec_v, ill}, 3'b100);
    end
  endtask

  initial begin
    void'($urandom(SEED));
    #1;
    // R11: reset outputs
    check("R11 reset outputs", {act_vec(), opv, ill}, 14'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R11: held prefix lost on reset
    put(8'h72);
    gap();
    rst_n = 1'b0; #1; rst_n = 1'b1;
    put(8'h30);
    check("R11 prefix dropped by reset", {dec_v, mode, cnt}, {1'b1, 4'd2, 2'd1});
    put(8'h00);
    check("R9 operand after reset", opv, 1);
    gap();
    check("R12 no decode when idle", {act_vec(), opv, ill}, 14'h0);
    // directed
    instr("R3 sp-rel", 0, 8'h00, 0);
    instr("R3 accumulator", 0, 8'h40, 0);
    put(8'h5C);
    check("R3 reg16", {dec_v, mode, cnt}, {1'b1, 4'd6, 2'd0});
    instr("R4 [addr16]", 1, 8'h33, 0);
    put(8'h72); put(8'h6A);
    check("R4 [addr16]+X", {mode, idx_y, ind, wide, cnt}, {4'd13, 1'b0, 1'b1, 1'b1, 2'd2});
    put(8'h11); put(8'h22);
    instr("R5 imm8", 0, 8'hAB, 0);
    instr("R5 addr16+X", 0, 8'hD6, 0);
    put(8'h92); put(8'hC6);
    check("R6 [addr8]", {mode, ind, wide, cnt}, {4'd10, 1'b1, 1'b0, 2'd1});
    put(8'h00);
    put(8'h91); put(8'hD6);
    check("R6 [addr8]+Y", {mode, idx_y, ind, wide, cnt}, {4'd12, 1'b1, 1'b1, 1'b0, 2'd1});
    put(8'h00);
    instr("R7 prefix 90 index", 2, 8'hE6, 0);
    put(8'hFE);
    check("R8 LDW X-indexed uses Y", {mode, idx_y, rswap}, {4'd7, 1'b0, 1'b1});
    put(8'h90); put(8'hFE);
    check("R8 LDW 90 reversed", {mode, idx_y, rswap}, {4'd7, 1'b1, 1'b0});
    instr("R8 CPW sp-rel 90", 2, 8'h13, 0);
    instr("R10 misc", 0, 8'h9D, 0);
    instr("R10 reassigned", 0, 8'hAC, 0);
    put(8'h92); put(8'h40);
    check("R10 unsupported pair", {oth, mode, cnt}, {1'b1, 4'd0, 2'd0});
    // R2: double prefix
    put(8'h72);
    put(8'h90);
    check("R2 illegal pulse", {ill, dec_v, opv}, 3'b100);
    gap();
    check("R2 pulse ends", ill, 0);
    put(8'h6F);
    check("R2 next unprefixed", act_vec(), ref_vec(0, 8'h6F));
    put(8'h01);
    // R9: operand bytes look like prefixes, with gaps
    put(8'hCE); gap(); gap();
    put(8'h90);
    check("R9 prefix value as operand", {opv, dec_v, ill}, 3'b100);
    gap();
    put(8'h91);
    check("R9 second operand", {opv, dec_v}, 2'b10);
    put(8'h40);
    check("R9 back to decode", {dec_v, mode}, {1'b1, 4'd5});
    // random
    for (int i = 0; i < NRAND; i++) begin
      int p;
      logic [7:0] op;
      p  = ($urandom % 8 < 4) ? 0 : 1 + $urandom % 4;
      op = 8'($urandom);
      if (op inside {8'h72, 8'h90, 8'h91, 8'h92}) op = op ^ 8'h04;
      instr(p == 0 ? "R3/R5/R10 random" : "R4/R6/R7/R8 random", p, op, 1);
      if ($urandom % 5 == 0) gap();
    end
    gap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule